// File: doc/BRIEF.md
# Pair Enable Qualifier

This block produces four firing-permission signals, one for each pair of deployment channels (0-1, 2-3, 4-5, 6-7). Each permission comes from an asynchronous enable pin. The pin is first brought into the system clock domain. A minimum-high-time filter then rejects short pulses. After the qualified pin level drops, a hold timer keeps the permission asserted for a programmed time. The deployment sequencer uses the four outputs directly as plain level signals. They carry no data, so they have no handshake and no back-pressure.

Two tick inputs set the time base. `us_tick` is a one-cycle pulse every microsecond and drives the filter. `ms_tick` is a one-cycle pulse every millisecond and drives the hold timers. The register decoder writes the 2-bit hold codes for all four groups at once with a single strobe. Each group works independently of the others. A pin rise that passes the filter reloads that group's hold timer, which makes the hold retriggerable.

Top module: `pair_enable_qual`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every `en_func` bit is 0 and every stored hold code is 0. An active hold is cancelled by reset.
- R2: The qualified pin level goes high on the 14th `us_tick` seen while the synchronised pin stays high. A high period covering only 13 ticks leaves `en_func` at 0.
- R3: The qualified level falls on the third rising clock edge after the pin goes low: two synchroniser stages, then the filter register.
- R4: `en_func[g]` is the qualified level of group g OR'd with that group's hold-timer-active state.
- R5: Hold codes select the hold length in `ms_tick` pulses: 0 gives 0, 1 gives 128, 2 gives 256 and 3 gives 512. After the qualified level falls, `en_func` stays 1 until the programmed number of `ms_tick` pulses has arrived, then drops on the clock after the last one.
- R6: With code 0, `en_func` follows the qualified level exactly.
- R7: A rise of the qualified level reloads the hold timer from the hold code stored at that moment. This also applies while an earlier hold is still running.
- R8: A pin pulse that fails the filter neither asserts `en_func` nor reloads a running hold timer.
- R9: When `cfg_we` is 1, `cfg_sel[2g+1:2g]` is stored as the hold code of group g. Each group's pin affects only its own `en_func` bit.
- R10: `ms_tick` pulses that arrive while the qualified level is high do not shorten the hold that follows the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse every microsecond, filter time base |
| ms_tick | input | 1 | One-cycle pulse every millisecond, hold time base |
| en_pin | input | 4 | Asynchronous enable pins, bit g for channel pair g |
| cfg_we | input | 1 | Write strobe for the hold codes |
| cfg_sel | input | 8 | Hold codes, group g in bits [2g+1:2g] |
| en_func | output | 4 | Qualified firing permission per channel pair |

## Verification
The hardest case to reach is a retrigger in the middle of a hold. It takes a full filter pass while the hold counter sits part-way down, and then an exact count of the remaining ticks. The stimulus handles this by driving the tick inputs itself. It lets a known number of `ms_tick` pulses go by after a fall, re-raises the pin for exactly 14 or exactly 13 `us_tick` pulses, and then counts the remaining `ms_tick` pulses one short of the expected reload value and then one more. This separates a true reload (R7) from a rejected pulse (R8) and from a counter that keeps running while the pin is high (R10).

// File: rtl/peq_pkg.sv
package peq_pkg;
  // Hold length in ms ticks for a code: 0 -> 0, n -> unit << (n-1)
  function automatic int unsigned hold_len(input int unsigned code, input int unsigned unit);
    if (code == 0) return 0;
    return unit << (code - 1);
  endfunction
endpackage

// File: rtl/peq_sync.sv
module peq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/peq_filter.sv
module peq_filter #(
  parameter int FILT_TICKS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic tick,
  output logic filt
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (!lvl) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (!filt && tick) begin
      if (cnt == CW'(FILT_TICKS - 1)) filt <= 1'b1;
      else                            cnt  <= cnt + 1'b1;
    end
  end

  // R3: a low synchronised level clears the qualified level on the next edge
  assert_fall_prompt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl |=> !filt);

  // R2: qualification happens only on a tick while the level is high
  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt) |-> ($past(tick) && $past(lvl)));
endmodule

// File: rtl/peq_hold.sv
module peq_hold #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt,
  input  logic             ms_tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             active
);
  logic [CNT_W-1:0] cnt;
  logic             filt_d;
  logic             rise;

  assign rise = filt & ~filt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      filt_d <= 1'b0;
    end else begin
      filt_d <= filt;
      if (rise)                               cnt <= load_val;
      else if (!filt && ms_tick && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign active = (cnt != '0);

  // R10: the counter is frozen while the qualified level stays high
  assert_pause_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (filt && filt_d) |=> $stable(cnt));

  // R5: outside a reload the counter only steps down by one on a ms tick
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != $past(cnt)) && !$past(rise)) |-> ($past(ms_tick) && (cnt == $past(cnt) - 1'b1)));
endmodule

// File: rtl/pair_enable_qual.sv
module pair_enable_qual #(
  parameter int NUM_GRP     = 4,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TICKS  = 14,
  parameter int HOLD_UNIT   = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     us_tick,
  input  logic                     ms_tick,
  input  logic [NUM_GRP-1:0]       en_pin,
  input  logic                     cfg_we,
  input  logic [NUM_GRP*SEL_W-1:0] cfg_sel,
  output logic [NUM_GRP-1:0]       en_func
);
  import peq_pkg::*;

  localparam int NUM_CODES = 1 << SEL_W;
  localparam int MAX_HOLD  = HOLD_UNIT << (NUM_CODES - 2);
  localparam int CNT_W     = $clog2(MAX_HOLD + 1);

  logic [NUM_GRP*SEL_W-1:0] sel_q;
  logic [NUM_GRP-1:0]       pin_s, filt, hold_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (cfg_we) sel_q <= cfg_sel;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [SEL_W-1:0] code;
    logic [CNT_W-1:0] load_val;

    assign code     = sel_q[g*SEL_W +: SEL_W];
    assign load_val = CNT_W'(hold_len(int'(code), HOLD_UNIT));

    peq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(en_pin[g]), .q(pin_s[g]));

    peq_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s[g]), .tick(us_tick), .filt(filt[g]));

    peq_hold #(.CNT_W(CNT_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .filt(filt[g]), .ms_tick(ms_tick),
      .load_val(load_val), .active(hold_act[g]));

    assign en_func[g] = filt[g] | hold_act[g];

    // R4: a permission can only start from a qualified pin
    assert_start_from_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_func[g]) |-> filt[g]);

    // R5: permission ends only on a ms tick or with the qualified level
    assert_end_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_func[g]) |-> ($past(ms_tick) || $past(filt[g])));
  end
endmodule

// File: tb/sim_pair_enable_qual.sv
`timescale 1ns/1ps
module sim_pair_enable_qual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0, ms_tick = 1'b0, cfg_we = 1'b0;
  logic [3:0] en_pin = '0;
  logic [7:0] cfg_sel = '0;
  logic [3:0] en_func;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int grp; logic exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  pair_enable_qual u0 (.clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ms_tick(ms_tick),
    .en_pin(en_pin), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .en_func(en_func));

  // monitor: pops one expectation per cycle and compares
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (en_func[it.grp] !== it.exp) begin
        errors++;
        $display("FAIL %s grp %0d actual %b expected %b", it.tag, it.grp, en_func[it.grp], it.exp);
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_en(input int g, input logic e, input string tag);
    item_t it;
    it.grp = g; it.exp = e; it.tag = tag;
    sb.push_back(it);
    while (sb.size() > 0) step();
  endtask

  task automatic tick_us(input int n);
    for (int i = 0; i < n; i++) begin us_tick = 1; step(); us_tick = 0; step(2); end
  endtask

  task automatic tick_ms(input int n);
    for (int i = 0; i < n; i++) begin ms_tick = 1; step(); ms_tick = 0; step(); end
  endtask

  task automatic raise(input int g, input int n_us);
    en_pin[g] = 1'b1; step(3); tick_us(n_us); step(2);
  endtask

  task automatic drop(input int g);
    en_pin[g] = 1'b0; step(4);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_sel = v; cfg_we = 1; step(); cfg_we = 0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    for (int g = 0; g < 4; g++) expect_en(g, 1'b0, "R1 in reset");
    rst_n = 1'b1; step(2);
    for (int g = 0; g < 4; g++) expect_en(g, 1'b0, "R1 after reset");

    // R9 codes: g0=1, g1=2, g2=3, g3=0
    write_cfg(8'b00_11_10_01);

    // R2 / R8: 13 ticks fail the filter
    raise(0, 13);
    expect_en(0, 1'b0, "R2 13 ticks");
    drop(0);
    expect_en(0, 1'b0, "R8 short pulse");

    // R2 pass, R9 isolation, R10 pause, R5 128
    raise(0, 14);
    expect_en(0, 1'b1, "R2 14 ticks");
    for (int g = 1; g < 4; g++) expect_en(g, 1'b0, "R9 other groups idle");
    tick_ms(20);
    drop(0);
    expect_en(0, 1'b1, "R4 hold after fall");
    tick_ms(127);
    expect_en(0, 1'b1, "R10 R5 code1 before end");
    tick_ms(1);
    expect_en(0, 1'b0, "R5 code1 end");

    raise(1, 14); drop(1);
    tick_ms(255);
    expect_en(1, 1'b1, "R5 code2 before end");
    tick_ms(1);
    expect_en(1, 1'b0, "R5 code2 end");

    raise(2, 14); drop(2);
    tick_ms(511);
    expect_en(2, 1'b1, "R5 code3 before end");
    tick_ms(1);
    expect_en(2, 1'b0, "R5 code3 end");

    // R6 / R3 on code 0
    raise(3, 14);
    expect_en(3, 1'b1, "R6 follows high");
    en_pin[3] = 1'b0; step(2);
    expect_en(3, 1'b1, "R3 two edges after fall");
    expect_en(3, 1'b0, "R3 R6 third edge");

    // R7 retrigger mid-hold
    raise(0, 14); drop(0);
    tick_ms(100);
    raise(0, 14);
    expect_en(0, 1'b1, "R7 retrigger high");
    drop(0);
    tick_ms(127);
    expect_en(0, 1'b1, "R7 reloaded before end");
    tick_ms(1);
    expect_en(0, 1'b0, "R7 reloaded end");

    // R8 short pulse does not reload
    raise(0, 14); drop(0);
    tick_ms(100);
    raise(0, 13); drop(0);
    tick_ms(27);
    expect_en(0, 1'b1, "R8 no reload before end");
    tick_ms(1);
    expect_en(0, 1'b0, "R8 no reload end");

    // R7 reload uses code stored at rise: g0 set to code 2
    write_cfg(8'b00_11_10_10);
    raise(0, 14); drop(0);
    tick_ms(255);
    expect_en(0, 1'b1, "R7 new code before end");
    tick_ms(1);
    expect_en(0, 1'b0, "R7 new code end");

    // R1 reset cancels hold and clears codes
    raise(2, 14); drop(2);
    tick_ms(5);
    rst_n = 1'b0; step();
    expect_en(2, 1'b0, "R1 reset cancels hold");
    rst_n = 1'b1; step(2);
    raise(2, 14);
    expect_en(2, 1'b1, "R1 pin after reset");
    drop(2);
    expect_en(2, 1'b0, "R1 code cleared");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule